// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 64 interrupt inputs and presents one request line to a processor. Software programs it over a plain 32-bit register bus. Each input has three settings: an enable, a trigger mode (level or edge) and a priority level. An edge-mode input remembers a rising edge until software rewrites that input's configuration word. A level-mode input counts as pending only while it is held high.

From the pending, enabled inputs, the controller picks the one with the highest priority level. When two inputs have the same level, the lower index wins. The index of the winner is readable in the same cycle as the vector register. If nothing qualifies, that register reads as 64, which software treats as spurious. The request output passes through a global enable. An end-of-interrupt write drops the request for one cycle so that the processor sees a fresh edge. A soft-reset write clears every programmable setting. Each input also has a small register-set binding value, which software writes through one packed register and reads back per input.

Top module: `vic_top`

## Requirements
- R1: After reset both enable banks read 0, the vector register reads 64 and `irq` is low.
- R2: A write to the set-low (0x000) or set-high (0x004) address turns on the enable of every source whose bit is 1. Source n is bit n of the low bank, or bit n-32 of the high bank. Bits written as 0 leave their enables as they were. The set and clear addresses of a bank both read back that bank's current enable mask.
- R3: A write to the clear-low (0x008) or clear-high (0x00C) address turns off the enable of every source whose bit is 1. All other enables are left unchanged.
- R4: The configuration word of source n is at 0x100 + 8n. Bit 8 selects edge mode (1) or level mode (0), and bits [2:0] hold the priority level. The word reads back with every other bit as 0.
- R5: A level-mode source is pending exactly while its input is high.
- R6: An edge-mode source becomes pending on a rising edge of its input. It stays pending after the input falls, and it is released by a write to its configuration word.
- R7: Among the pending enabled sources, the highest priority level wins, and on equal levels the lowest index wins. A source that is not enabled is never selected.
- R8: The vector register (0x010) reads the winning index in the same cycle. It reads 64 when no source qualifies.
- R9: `irq` is high one cycle after a source qualifies, but only while bit 0 of the global-enable register (0x018, readable) is 1.
- R10: A write of any value to 0x014 forces `irq` low in the following cycle. `irq` is then re-evaluated in the cycle after that.
- R11: Writing 1 to bit 0 of 0x01C clears the enables, configuration words, binding values, edge latches and global enable. `irq` is low in the next cycle.
- R12: A write to 0x020 stores bits [3:0] as the binding value of the source named in bits [21:16]. That value reads back at 0x104 + 8n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| src_in | input | 64 | Interrupt inputs, one per source |
| irq | output | 1 | Registered interrupt request to the processor |

## Verification
Arbitration is exercised with three enabled level sources held high together. Two of them share the top priority level, so the tie rule is separated from the level rule. Disabling the winners one by one then shows that the enable mask takes part in selection, while a high but disabled input never appears. A one-cycle pulse on an edge-mode input shows the latching behaviour: the pending state outlives the pulse, and only a configuration rewrite clears it, which a level source cannot show. Single-bit and multi-bit set and clear writes show that bits written as 0 leave the other enables untouched.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam int REG_W         = 32;
  localparam int BANK_W        = 32;
  localparam int EDGE_BIT      = 8;
  localparam int BIND_SRC_LSB  = 16;
  localparam int CFG_BASE      = 'h100;
  localparam int CFG_STRIDE_SH = 3;

  localparam int OFS_SET_LO = 'h000;
  localparam int OFS_SET_HI = 'h004;
  localparam int OFS_CLR_LO = 'h008;
  localparam int OFS_CLR_HI = 'h00C;
  localparam int OFS_VECTOR = 'h010;
  localparam int OFS_EOI    = 'h014;
  localparam int OFS_GEN    = 'h018;
  localparam int OFS_SRST   = 'h01C;
  localparam int OFS_BIND   = 'h020;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_SET_LO,
    SEL_SET_HI,
    SEL_CLR_LO,
    SEL_CLR_HI,
    SEL_VECTOR,
    SEL_EOI,
    SEL_GEN,
    SEL_SRST,
    SEL_BIND,
    SEL_CFG,
    SEL_BINDRD
  } reg_sel_e;

  // Candidate beats the current best only on a strictly higher level,
  // so a scan in index order keeps the lowest index on ties.
  function automatic logic outranks(input logic have_best,
                                    input int unsigned cand_lvl,
                                    input int unsigned best_lvl);
    return !have_best || (cand_lvl > best_lvl);
  endfunction

endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int PRIO_W = 3,
  parameter int BIND_W = 4,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = $clog2(NSRC),
  parameter int VEC_W  = IDX_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_en,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [REG_W-1:0]              bus_wdata,
  input  logic [VEC_W-1:0]              vector,
  output logic [REG_W-1:0]              bus_rdata,
  output logic [NSRC-1:0]               en_mask,
  output logic [NSRC-1:0]               edge_mode,
  output logic [NSRC-1:0][PRIO_W-1:0]   prio,
  output logic [NSRC-1:0]               cfg_wr,
  output logic                          gen_en,
  output logic                          eoi_wr,
  output logic                          soft_rst_wr
);

  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + (NSRC << CFG_STRIDE_SH));

  logic                      wr;
  reg_sel_e                  sel;
  logic [IDX_W-1:0]          cfg_idx;
  logic [IDX_W-1:0]          bind_idx;
  logic [NSRC-1:0][BIND_W-1:0] bind_val;
  logic [BANK_W-1:0]         en_lo;
  logic [BANK_W-1:0]         en_hi;

  assign wr       = bus_en & bus_we;
  assign bind_idx = bus_wdata[BIND_SRC_LSB +: IDX_W];

  always_comb begin
    sel     = SEL_NONE;
    cfg_idx = IDX_W'((bus_addr - CFG_LO) >> CFG_STRIDE_SH);
    if (bus_addr >= CFG_LO && bus_addr < CFG_HI) begin
      sel = bus_addr[2] ? SEL_BINDRD : SEL_CFG;
    end else begin
      case (bus_addr)
        ADDR_W'(OFS_SET_LO): sel = SEL_SET_LO;
        ADDR_W'(OFS_SET_HI): sel = SEL_SET_HI;
        ADDR_W'(OFS_CLR_LO): sel = SEL_CLR_LO;
        ADDR_W'(OFS_CLR_HI): sel = SEL_CLR_HI;
        ADDR_W'(OFS_VECTOR): sel = SEL_VECTOR;
        ADDR_W'(OFS_EOI):    sel = SEL_EOI;
        ADDR_W'(OFS_GEN):    sel = SEL_GEN;
        ADDR_W'(OFS_SRST):   sel = SEL_SRST;
        ADDR_W'(OFS_BIND):   sel = SEL_BIND;
        default:             sel = SEL_NONE;
      endcase
    end
  end

  assign eoi_wr      = wr && (sel == SEL_EOI);
  assign soft_rst_wr = wr && (sel == SEL_SRST) && bus_wdata[0];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int BANK = i / BANK_W;
    localparam int BITP = i % BANK_W;
    localparam reg_sel_e SET_SEL = (BANK == 0) ? SEL_SET_LO : SEL_SET_HI;
    localparam reg_sel_e CLR_SEL = (BANK == 0) ? SEL_CLR_LO : SEL_CLR_HI;

    logic set_hit, clr_hit, bind_hit;
    assign set_hit   = wr && (sel == SET_SEL) && bus_wdata[BITP];
    assign clr_hit   = wr && (sel == CLR_SEL) && bus_wdata[BITP];
    assign cfg_wr[i] = wr && (sel == SEL_CFG) && (cfg_idx == IDX_W'(i));
    assign bind_hit  = wr && (sel == SEL_BIND) && (bind_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n || soft_rst_wr) begin
        en_mask[i]   <= 1'b0;
        edge_mode[i] <= 1'b0;
        prio[i]      <= '0;
        bind_val[i]  <= '0;
      end else begin
        if (clr_hit)      en_mask[i] <= 1'b0;
        else if (set_hit) en_mask[i] <= 1'b1;
        if (cfg_wr[i]) begin
          edge_mode[i] <= bus_wdata[EDGE_BIT];
          prio[i]      <= bus_wdata[PRIO_W-1:0];
        end
        if (bind_hit) bind_val[i] <= bus_wdata[BIND_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst_wr)      gen_en <= 1'b0;
    else if (wr && sel == SEL_GEN)  gen_en <= bus_wdata[0];
  end

  always_comb begin
    en_lo = '0;
    en_hi = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (k < BANK_W) en_lo[k % BANK_W] = en_mask[k];
      else            en_hi[k % BANK_W] = en_mask[k];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_SET_LO, SEL_CLR_LO: bus_rdata = en_lo;
      SEL_SET_HI, SEL_CLR_HI: bus_rdata = en_hi;
      SEL_VECTOR:             bus_rdata = REG_W'(vector);
      SEL_GEN:                bus_rdata[0] = gen_en;
      SEL_CFG: begin
        bus_rdata[EDGE_BIT]     = edge_mode[cfg_idx];
        bus_rdata[PRIO_W-1:0]   = prio[cfg_idx];
      end
      SEL_BINDRD:             bus_rdata[BIND_W-1:0] = bind_val[cfg_idx];
      default:                bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/vic_pending.sv
module vic_pending #(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] edge_mode,
  input  logic [NSRC-1:0] cfg_wr,
  input  logic            soft_rst_wr,
  output logic [NSRC-1:0] pending,
  output logic [NSRC-1:0] rise
);

  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] latch_q;

  assign rise = src_in & ~src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_in;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_latch
    // A new edge in the same cycle as a config rewrite is kept.
    always_ff @(posedge clk) begin
      if (!rst_n || soft_rst_wr)        latch_q[i] <= 1'b0;
      else if (edge_mode[i] && rise[i]) latch_q[i] <= 1'b1;
      else if (cfg_wr[i])               latch_q[i] <= 1'b0;
    end
    assign pending[i] = edge_mode[i] ? latch_q[i] : src_in[i];
  end

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             cand,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio,
  output logic                        sel_valid,
  output logic [IDX_W-1:0]            sel_idx
);

  logic [PRIO_W-1:0] best_lvl;

  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    best_lvl  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && outranks(sel_valid, int'(prio[i]), int'(best_lvl))) begin
        sel_valid = 1'b1;
        sel_idx   = IDX_W'(i);
        best_lvl  = prio[i];
      end
    end
  end

endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int PRIO_W = 3,
  parameter int BIND_W = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic              irq
);

  localparam int IDX_W = $clog2(NSRC);
  localparam int VEC_W = IDX_W + 1;

  logic [NSRC-1:0]             en_mask;
  logic [NSRC-1:0]             edge_mode;
  logic [NSRC-1:0][PRIO_W-1:0] prio;
  logic [NSRC-1:0]             cfg_wr;
  logic [NSRC-1:0]             pending;
  logic [NSRC-1:0]             rise;
  logic [NSRC-1:0]             cand;
  logic                        gen_en;
  logic                        eoi_wr;
  logic                        soft_rst_wr;
  logic                        sel_valid;
  logic [IDX_W-1:0]            sel_idx;
  logic [VEC_W-1:0]            vector;
  logic                        irq_q;

  vic_regs #(
    .NSRC(NSRC), .PRIO_W(PRIO_W), .BIND_W(BIND_W), .ADDR_W(ADDR_W),
    .IDX_W(IDX_W), .VEC_W(VEC_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .vector(vector), .bus_rdata(bus_rdata),
    .en_mask(en_mask), .edge_mode(edge_mode), .prio(prio), .cfg_wr(cfg_wr),
    .gen_en(gen_en), .eoi_wr(eoi_wr), .soft_rst_wr(soft_rst_wr)
  );

  vic_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .edge_mode(edge_mode),
    .cfg_wr(cfg_wr), .soft_rst_wr(soft_rst_wr), .pending(pending), .rise(rise)
  );

  assign cand = pending & en_mask;

  vic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .cand(cand), .prio(prio), .sel_valid(sel_valid), .sel_idx(sel_idx)
  );

  assign vector = sel_valid ? {1'b0, sel_idx} : VEC_W'(NSRC);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= gen_en && sel_valid && !eoi_wr && !soft_rst_wr;
  end

  assign irq = irq_q;

endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NSRC = 64,
  parameter int IDX_W = $clog2(NSRC),
  parameter int VEC_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             gen_en,
  input logic             eoi_wr,
  input logic             soft_rst_wr,
  input logic [NSRC-1:0]  en_mask,
  input logic [NSRC-1:0]  cand,
  input logic             sel_valid,
  input logic [IDX_W-1:0] sel_idx,
  input logic [VEC_W-1:0] vector
);

  AST_IRQ_NEEDS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gen_en)); // R9
  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(sel_valid)); // R9
  AST_EOI_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> !irq); // R10
  AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_wr |=> (en_mask == '0 && !gen_en && !irq)); // R11
  AST_VEC_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> (vector == VEC_W'(NSRC))); // R8
  AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (en_mask[sel_idx] && cand[sel_idx])); // R7

endmodule

bind vic_top vic_checker #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .gen_en(gen_en), .eoi_wr(eoi_wr),
  .soft_rst_wr(soft_rst_wr), .en_mask(en_mask), .cand(cand),
  .sel_valid(sel_valid), .sel_idx(sel_idx), .vector(vector)
);

// File: tb/vic_top_bench.sv
`timescale 1ns/1ps
module vic_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  vic_top u_vic_top (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src), .irq(irq)
  );

  function automatic logic [11:0] cfg_addr(input int n);
    return 12'(32'h100 + n * 8);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic clear_all();
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'h00C, 32'hFFFF_FFFF);
    src = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h000, d); chk("R1 enable low", d, 0);
    rd(12'h004, d); chk("R1 enable high", d, 0);
    rd(12'h010, d); chk("R1 vector", d, 64);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(12'h000, 32'h0000_00F0);
    rd(12'h000, d); chk("R2 set low", d, 32'h0000_00F0);
    wr(12'h000, 32'h0000_0001);
    rd(12'h008, d); chk("R2 zero bits keep", d, 32'h0000_00F1);
    wr(12'h004, 32'h8000_0001);
    rd(12'h00C, d); chk("R2 set high", d, 32'h8000_0001);
    wr(12'h008, 32'h0000_0030);
    rd(12'h000, d); chk("R3 clear low", d, 32'h0000_00C1);
    wr(12'h00C, 32'h0000_0001);
    rd(12'h004, d); chk("R3 clear high", d, 32'h8000_0000);
    clear_all();
  endtask

  task automatic t_config();
    logic [31:0] d;
    wr(cfg_addr(5), 32'h0000_0105);
    rd(cfg_addr(5), d); chk("R4 cfg readback", d, 32'h0000_0105);
    wr(cfg_addr(6), 32'hFFFF_FFFF);
    rd(cfg_addr(6), d); chk("R4 cfg field mask", d, 32'h0000_0107);
    wr(cfg_addr(5), 0);
    wr(cfg_addr(6), 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(cfg_addr(3), 32'h2);
    wr(12'h000, 32'h8);
    src[3] = 1'b1;
    rd(12'h010, d); chk("R5 level pending", d, 3);
    src[3] = 1'b0;
    rd(12'h010, d); chk("R5 level released", d, 64);
    clear_all();
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(cfg_addr(40), 32'h101);
    wr(12'h004, 32'h100);
    @(negedge clk); src[40] = 1'b1;
    @(negedge clk); src[40] = 1'b0;
    repeat (2) @(negedge clk);
    rd(12'h010, d); chk("R6 edge latched", d, 40);
    wr(cfg_addr(40), 32'h101);
    rd(12'h010, d); chk("R6 edge released by cfg write", d, 64);
    wr(cfg_addr(40), 0);
    clear_all();
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(cfg_addr(10), 32'h3);
    wr(cfg_addr(20), 32'h5);
    wr(cfg_addr(30), 32'h5);
    wr(cfg_addr(2), 32'h7);
    wr(12'h000, (32'h1 << 10) | (32'h1 << 20) | (32'h1 << 30));
    src[2] = 1'b1; src[10] = 1'b1; src[20] = 1'b1; src[30] = 1'b1;
    rd(12'h010, d); chk("R7 tie lowest index", d, 20);
    wr(12'h008, 32'h1 << 20);
    rd(12'h010, d); chk("R7 next of equal level", d, 30);
    wr(12'h008, 32'h1 << 30);
    rd(12'h010, d); chk("R7 lower level, disabled ignored", d, 10);
    wr(cfg_addr(2), 0);
    clear_all();
  endtask

  task automatic t_global_eoi();
    logic [31:0] d;
    wr(12'h000, 32'h1 << 10);
    src[10] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 irq gated off", {31'b0, irq}, 0);
    rd(12'h010, d); chk("R8 vector without gen", d, 10);
    wr(12'h018, 1);
    rd(12'h018, d); chk("R9 gen readback", d, 1);
    chk("R9 irq on", {31'b0, irq}, 1);
    wr(12'h014, 32'h1234_5678);
    chk("R10 irq gap", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R10 irq back", {31'b0, irq}, 1);
    src[10] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 irq drops with source", {31'b0, irq}, 0);
    clear_all();
  endtask

  task automatic t_bind();
    logic [31:0] d;
    wr(12'h020, (32'd7 << 16) | 32'h3A);
    rd(12'h104 + 12'd56, d); chk("R12 bind src 7", d, 32'hA);
    wr(12'h020, (32'd63 << 16) | 32'h5);
    rd(12'h2FC, d); chk("R12 bind src 63", d, 32'h5);
    rd(12'h10C, d); chk("R12 other source untouched", d, 0);
  endtask

  task automatic t_softreset();
    logic [31:0] d;
    wr(cfg_addr(5), 32'h104);
    wr(12'h000, 32'h20);
    wr(12'h018, 1);
    src[5] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 irq before reset", {31'b0, irq}, 1);
    wr(12'h01C, 1);
    chk("R11 irq cleared", {31'b0, irq}, 0);
    rd(12'h000, d);       chk("R11 enables cleared", d, 0);
    rd(12'h018, d);       chk("R11 gen cleared", d, 0);
    rd(cfg_addr(5), d);   chk("R11 cfg cleared", d, 0);
    rd(12'h104 + 12'd56, d); chk("R11 bind cleared", d, 0);
    rd(12'h010, d);       chk("R11 vector spurious", d, 64);
    src = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enables();
    t_config();
    t_level();
    t_edge();
    t_priority();
    t_global_eoi();
    t_bind();
    t_softreset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule